// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block multiplies two 32-bit unsigned operands into a full 64-bit product. It runs one add-and-shift step per clock. A start pulse, given while the block is idle, captures both operands. The multiplier operand goes into the low half of a 64-bit accumulator and the upper half is cleared. Thirty-two steps follow. In each step, a set accumulator LSB adds the multiplicand into the upper half. The whole accumulator then moves right by one place, and the carry out of that add enters the top bit.

The add is done by an internal 32-bit carry-select adder made of 4-bit groups. Every group above the lowest one works out its sum and carry twice: once for an incoming carry of 0 and once for an incoming carry of 1. The carry from the group below then picks between the two results. The lowest group only ever sees a carry-in of 0, so it has a single chain.

`busy_o` is high while the steps run. `done_o` pulses once when the product is ready. The product then stays on `prod_o` until the next accepted start.

Top module: `shiftadd_mul`

## Requirements
- R1: After `done_o` pulses, `prod_o` equals the exact 64-bit product of the captured multiplicand and multiplier, with no truncation.
- R2: In the cycle after an accepted start, `prod_o[63:32]` is 0 and `prod_o[31:0]` holds the multiplier operand.
- R3: `busy_o` stays high for exactly 32 consecutive cycles after an accepted start. `done_o` is high for one cycle only, the first cycle in which `busy_o` is low again.
- R4: On each step the accumulator shifts right by one and bit 0 is discarded. When the LSB was 0, the upper half is carried down unchanged and bit 63 becomes 0.
- R5: When the LSB is 1, the carry-select adder (4-bit groups, lowest carry-in 0) returns the 33-bit sum of the upper half and the multiplicand. Its carry becomes bit 63 after the shift.
- R6: A start raised while `busy_o` is high is ignored. The operands are not recaptured and the run's length and result do not change.
- R7: While idle and with no start, `prod_o` keeps its value.
- R8: A synchronous reset clears `busy_o`, `done_o` and `prod_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start request, accepted only while idle |
| mcand_i | input | 32 | Multiplicand operand |
| mplier_i | input | 32 | Multiplier operand |
| busy_o | output | 1 | High while the steps run |
| done_o | output | 1 | One-cycle pulse when the product is ready |
| prod_o | output | 64 | Accumulator contents, the final product after done |

## Verification
The operand patterns are chosen to separate different faults:
- A zero operand on either side checks that a step with no add still shifts and does not inject a carry.
- All-ones times all-ones forces a carry through all eight adder groups on nearly every step, so the carry-select muxing and the carry fed into bit 63 are both exercised.
- The single-high-bit pair and the fixed large pair with its known product check bit placement.
- Random pairs cover mixed add/no-add sequences.
- A start raised mid-run with different operands checks that the block ignores it.

A cycle-level reference model in the bench is compared with the accumulator on every clock, so a wrong intermediate step is caught even if it happens to cancel out later.

// File: rtl/mul_pkg.sv
package mul_pkg;

  typedef enum logic {ST_IDLE, ST_RUN} mul_state_e;

  // One bit position of an adder: returns {carry_out, sum} from generate/propagate.
  function automatic logic [1:0] bit_add(input logic a, input logic b, input logic c);
    logic g;
    logic p;
    g = a & b;
    p = a ^ b;
    return {g | (p & c), p ^ c};
  endfunction

endpackage

// File: rtl/rca_group.sv
module rca_group #(
  parameter int   W   = 4,
  parameter logic CIN = 1'b0
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] s_o,
  output logic         co_o
);
  logic       c_run;
  logic [1:0] r;

  always_comb begin
    c_run = CIN;
    r     = 2'b00;
    s_o   = '0;
    for (int i = 0; i < W; i++) begin
      r      = mul_pkg::bit_add(a_i[i], b_i[i], c_run);
      s_o[i] = r[0];
      c_run  = r[1];
    end
    co_o = c_run;
  end
endmodule

// File: rtl/csel_group.sv
module csel_group #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         ci_i,
  output logic [W-1:0] s_o,
  output logic         co_o
);
  logic [W-1:0] s_c0, s_c1;
  logic         co_c0, co_c1;

  rca_group #(.W(W), .CIN(1'b0)) u_c0 (.a_i(a_i), .b_i(b_i), .s_o(s_c0), .co_o(co_c0));
  rca_group #(.W(W), .CIN(1'b1)) u_c1 (.a_i(a_i), .b_i(b_i), .s_o(s_c1), .co_o(co_c1));

  assign s_o  = ci_i ? s_c1  : s_c0;
  assign co_o = ci_i ? co_c1 : co_c0;
endmodule

// File: rtl/csel_adder.sv
module csel_adder #(
  parameter int W     = 32,
  parameter int GRP_W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] s_o,
  output logic         co_o
);
  localparam int NG = W / GRP_W;

  logic [NG:1] c;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    if (g == 0) begin : g_low
      rca_group #(.W(GRP_W), .CIN(1'b0)) u_grp (
        .a_i (a_i[GRP_W-1:0]),
        .b_i (b_i[GRP_W-1:0]),
        .s_o (s_o[GRP_W-1:0]),
        .co_o(c[1])
      );
    end else begin : g_sel
      csel_group #(.W(GRP_W)) u_grp (
        .a_i (a_i[g*GRP_W +: GRP_W]),
        .b_i (b_i[g*GRP_W +: GRP_W]),
        .ci_i(c[g]),
        .s_o (s_o[g*GRP_W +: GRP_W]),
        .co_o(c[g+1])
      );
    end
  end

  assign co_o = c[NG];
endmodule

// File: rtl/mul_seq_ctrl.sv
module mul_seq_ctrl #(
  parameter int ITERS = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  import mul_pkg::*;

  localparam int CW = (ITERS > 1) ? $clog2(ITERS) : 1;

  mul_state_e      state_q;
  logic [CW-1:0]   cnt_q;
  logic            last_step;

  assign busy_o    = (state_q == ST_RUN);
  assign load_o    = (state_q == ST_IDLE) && start_i;
  assign step_o    = busy_o;
  assign last_step = (cnt_q == CW'(ITERS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
          end
        end
        ST_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (last_step) begin
            state_q <= ST_IDLE;
            done_o  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/shiftadd_mul.sv
module shiftadd_mul #(
  parameter int OP_W  = 32,
  parameter int GRP_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic [OP_W-1:0]     mcand_i,
  input  logic [OP_W-1:0]     mplier_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [2*OP_W-1:0]   prod_o
);
  localparam int PW = 2 * OP_W;

  logic            load, step;
  logic [PW-1:0]   acc_q;
  logic [OP_W-1:0] mcand_q;
  logic [OP_W-1:0] acc_hi;
  logic            add_en;
  logic [OP_W-1:0] addend;
  logic [OP_W-1:0] add_sum;
  logic            add_co;
  logic [PW-1:0]   acc_nxt;

  mul_seq_ctrl #(.ITERS(OP_W)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .start_i(start_i),
    .load_o (load),
    .step_o (step),
    .busy_o (busy_o),
    .done_o (done_o)
  );

  assign acc_hi = acc_q[PW-1:OP_W];
  assign add_en = step & acc_q[0];
  assign addend = mcand_q & {OP_W{add_en}};

  csel_adder #(.W(OP_W), .GRP_W(GRP_W)) u_add (
    .a_i (acc_hi),
    .b_i (addend),
    .s_o (add_sum),
    .co_o(add_co)
  );

  assign acc_nxt = {add_co, add_sum, acc_q[OP_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      mcand_q <= '0;
    end else if (load) begin
      acc_q   <= {{OP_W{1'b0}}, mplier_i};
      mcand_q <= mcand_i;
    end else if (step) begin
      acc_q   <= acc_nxt;
    end
  end

  assign prod_o = acc_q;
endmodule

// File: rtl/shiftadd_mul_chk.sv
module shiftadd_mul_chk #(
  parameter int OP_W = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                start_i,
  input logic [OP_W-1:0]     mplier_i,
  input logic                busy_o,
  input logic                done_o,
  input logic [2*OP_W-1:0]   prod_o,
  input logic [OP_W-1:0]     mcand_q,
  input logic [OP_W-1:0]     acc_hi,
  input logic                add_en,
  input logic [OP_W-1:0]     add_sum,
  input logic                add_co
);
  localparam int PW = 2 * OP_W;
  localparam int RW = $clog2(OP_W + 2);

  logic [RW-1:0] run_len;

  always_ff @(posedge clk) begin
    if (rst)         run_len <= '0;
    else if (busy_o) run_len <= run_len + 1'b1;
    else             run_len <= '0;
  end

  // R2: load places the multiplier low and clears the upper half
  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> (prod_o[PW-1:OP_W] == '0) && (prod_o[OP_W-1:0] == $past(mplier_i)));

  // R3: run length and done pulse
  p_busy_len_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> (run_len == RW'(OP_W)));
  p_done_edge_r3: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $fell(busy_o));
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R4: shift discards bit 0; a no-add step brings the upper half down with a 0 on top
  p_shift_low_r4: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> prod_o[OP_W-2:0] == $past(prod_o[OP_W-1:1]));
  p_noadd_r4: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !prod_o[0]) |=> (prod_o[PW-2:OP_W-1] == $past(prod_o[PW-1:OP_W])) && !prod_o[PW-1]);

  // R5: carry-select adder agrees with arithmetic sum
  p_csel_sum_r5: assert property (@(posedge clk) disable iff (rst)
    add_en |-> ({add_co, add_sum} == ({1'b0, acc_hi} + {1'b0, mcand_q})));

  // R6: operands are not recaptured during a run
  p_ignore_r6: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> $stable(mcand_q));

  // R7: idle hold
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !start_i) |=> $stable(prod_o));

  // R8: reset state
  p_reset_r8: assert property (@(posedge clk)
    rst |=> (!busy_o && !done_o && prod_o == '0));
endmodule

bind shiftadd_mul shiftadd_mul_chk #(.OP_W(OP_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start_i (start_i),
  .mplier_i(mplier_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .prod_o  (prod_o),
  .mcand_q (mcand_q),
  .acc_hi  (acc_hi),
  .add_en  (add_en),
  .add_sum (add_sum),
  .add_co  (add_co)
);

// File: tb/shiftadd_mul_tb.sv
module shiftadd_mul_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [31:0] mcand_i = '0;
  logic [31:0] mplier_i = '0;
  logic        busy_o, done_o;
  logic [63:0] prod_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // reference model state
  logic [63:0] m_acc = '0;
  logic [31:0] m_mc  = '0;
  bit          m_busy = 0, m_done = 0;
  int          m_left = 0;

  always #5 clk = ~clk;

  shiftadd_mul u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .mcand_i(mcand_i), .mplier_i(mplier_i),
    .busy_o(busy_o), .done_o(done_o), .prod_o(prod_o)
  );

  always @(posedge clk) begin
    logic [63:0] t;
    logic [63:0] old;
    if (rst) begin
      m_acc = '0; m_busy = 0; m_done = 0; m_left = 0;
    end else begin
      m_done = 0;
      if (!m_busy && start_i) begin
        m_acc = {32'd0, mplier_i}; m_mc = mcand_i; m_busy = 1; m_left = 32;
      end else if (m_busy) begin
        old   = m_acc;
        t     = (old >> 32) + (old[0] ? {32'd0, m_mc} : 64'd0);
        m_acc = (t << 31) | (old[31:0] >> 1);
        m_left--;
        if (m_left == 0) begin m_busy = 0; m_done = 1; end
      end
    end
  end

  // per-cycle comparison against the model (R4, R5)
  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (busy_o !== m_busy || done_o !== m_done || prod_o !== m_acc) begin
        fails++;
        $display("FAIL R4/R5 cycle compare: busy=%0b done=%0b prod=%h expected busy=%0b done=%0b prod=%h",
                 busy_o, done_o, prod_o, m_busy, m_done, m_acc);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than 150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_mul(input logic [31:0] a, input logic [31:0] b, input bit poke);
    logic [63:0] exp;
    int n;
    exp = {32'd0, a} * {32'd0, b};
    mcand_i = a; mplier_i = b; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R2 load", prod_o, {32'd0, b});
    n = 0;
    while (busy_o && n < 40) begin
      n++;
      if (poke && n == 5) begin
        start_i = 1'b1; mcand_i = ~a; mplier_i = ~b;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    chk("R3 busy length", 64'(n), 64'd32);
    chk("R3 done pulse", {63'd0, done_o}, 64'd1);
    chk(poke ? "R6 ignored start, product" : "R1 product", prod_o, exp);
    repeat (3) @(negedge clk);
    chk("R3 done cleared", {63'd0, done_o}, 64'd0);
    chk("R7 hold", prod_o, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset busy", {63'd0, busy_o}, 64'd0);
    chk("R8 reset done", {63'd0, done_o}, 64'd0);
    chk("R8 reset prod", prod_o, 64'd0);
    rst = 1'b0;
    @(negedge clk);

    run_mul(32'd0, 32'hDEADBEEF, 0);            // R1 zero multiplicand
    run_mul(32'h12345678, 32'd0, 0);            // R1 zero multiplier
    run_mul(32'hFFFFFFFF, 32'hFFFFFFFF, 0);     // R5 carry through every group
    chk("R5 all-ones product", prod_o, 64'hFFFFFFFE00000001);
    run_mul(32'd3782682799, 32'd1404927549, 0); // R1 fixed pair
    chk("R1 fixed pair", prod_o, 64'd5314395273443529651);
    run_mul(32'h80000000, 32'h80000000, 0);
    chk("R1 top bits", prod_o, 64'h4000000000000000);
    run_mul(32'hFFFFFFFF, 32'd1, 0);
    run_mul(32'h0F0F0F0F, 32'hAAAAAAAA, 1);     // R6 start during run
    for (int i = 0; i < 20; i++) run_mul($urandom, $urandom, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule